// File: doc/BRIEF.md
# NAND Flash Strobe Sequencer

This block turns single-word front-end accesses into correctly timed strobe cycles on an 8-bit raw NAND flash bus. A write to the command port runs one bus cycle with the command-latch line high. A write to the address port does the same with the address-latch line high. A data-port write drives a byte with the write strobe, and a data-port read pulses the read strobe and returns the byte it samples. Each cycle walks through setup, active pulse and hold intervals. The block then waits a programmable ready delay before it accepts the next access. The interval lengths come from a single timing word that holds one set of counts for read strobes and another for write strobes.

The front end uses a valid/ready handshake. An access that is offered while a bus cycle is still running stays stalled until the sequencer is idle again. Beyond the bus cycles, the front end gives access to a configuration register that holds the chip-enable request, a status word that reflects the flash ready/busy pin, the timing word, and a control word whose reset bit clears the configuration.

Top module: `nand_strobe_seq`

## Requirements
- R1: After reset, no bus cycle runs: both strobes are high, both latch lines and the data drive are low, chip enable is released, the timing word reads as zero and `reqReady` is high.
- R2: The timing word is register offset 6. Its low half governs read strobes: setup in bits [3:0], hold in [7:4], width in [11:8] and ready delay in [15:12]. Its high half governs every write-type cycle with the same field order: setup in [19:16], hold in [23:20], width in [27:24] and ready delay in [31:28]. The word reads back unchanged.
- R3: Each bus cycle holds its strobe inactive for setup+1 clocks, then active (low) for width+1 clocks, then inactive for hold+1 clocks. It then waits delay clocks, and a delay of zero means no wait.
- R4: A write to offset 2 (command) runs a write cycle with `nandCle` high from setup through hold. A write to offset 1 (address) does the same with `nandAle` high. The two latch lines are never high together.
- R5: A write to offset 0 runs a write cycle with neither latch line high. For all write-type cycles, byte [7:0] of the write data is driven with `nandDataOe` high from setup through hold. A read of offset 0 pulses `nandReN` and never drives the bus.
- R6: A data read samples `nandDataIn` on the last clock of the active read pulse. The byte, zero-extended to 32 bits, is returned with a one-clock `rspValid` in the clock that follows, which is also the clock in which `nandReN` returns high.
- R7: `busy` is high, and `reqReady` low, from the first setup clock until the ready delay ends. An access held valid while busy waits, and the sequencer starts it as soon as it is ready.
- R8: Bit 5 of the configuration register (offset 4) drives `nandCeN` low while it is set and releases it when it is cleared.
- R9: Reading offset 5 returns the `nandRdy` pin in bit 0, where 1 means ready, and zeros in all other bits.
- R10: Writing the control word (offset 3) with bit 2 set clears the configuration register, so chip enable is released. The timing word is kept.
- R11: A read of any offset other than 0 completes in one clock and returns its data with `rspValid` in the next clock. Offsets 1, 2, 3 and 7 read as zero, and writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Front-end access request |
| reqReady | output | 1 | Access accepted on this clock when high with reqValid |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqAddr | input | 3 | Register offset |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Read data valid for one clock |
| rspData | output | 32 | Read data |
| busy | output | 1 | A bus cycle or its ready delay is in progress |
| nandCeN | output | 1 | Chip enable, active low |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write strobe, active low |
| nandReN | output | 1 | Read strobe, active low |
| nandDataOut | output | 8 | Byte driven onto the flash bus |
| nandDataOe | output | 1 | Output enable for nandDataOut |
| nandDataIn | input | 8 | Byte read from the flash bus |
| nandRdy | input | 1 | Flash ready/busy pin, 1 = ready |

## Verification
The assertions assume that the front end follows the handshake: a request stays stable until it is accepted, and `busy` can only rise after `reqValid` was seen. The stimulus honours this by changing inputs only on falling clock edges, and by holding each access until `reqReady` has been seen high before the accepting edge. Read data on `nandDataIn` changes on every clock, so only sampling on the correct pulse clock returns the value the model predicts. The timing words that are exercised include all zeros, all ones and a mixed word, so that the read and write field sets can each be told apart.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  // register offsets on the front end
  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_ADDR = 3'd1;
  localparam logic [2:0] A_CMD  = 3'd2;
  localparam logic [2:0] A_CTRL = 3'd3;
  localparam logic [2:0] A_CFG  = 3'd4;
  localparam logic [2:0] A_STAT = 3'd5;
  localparam logic [2:0] A_TIME = 3'd6;

  localparam int CE_BIT  = 5;
  localparam int RST_BIT = 2;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_PULSE, PH_HOLD, PH_WAIT
  } phase_t;

  typedef enum logic [1:0] {
    CY_CMD, CY_ADDR, CY_WDATA, CY_RDATA
  } cycle_t;

  // control -> datapath
  typedef struct packed {
    logic   accept;   // front-end access taken this clock
    logic   launch;   // access starts a bus cycle
    logic   capture;  // last clock of read pulse
    logic   pulse;    // strobe active
    logic   frame;    // setup, pulse or hold
    cycle_t kind;     // kind of the running cycle
  } seq_strobe_t;

endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int FIELD_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [2:0]           reqAddr,
  input  logic [8*FIELD_W-1:0] timing,
  output logic                 reqReady,
  output logic                 busy,
  output seq_strobe_t          strobe
);

  localparam int SET_W = 4 * FIELD_W;

  phase_t              phase;
  cycle_t              kind;
  cycle_t              newKind;
  logic [FIELD_W-1:0]  cnt;
  logic                accept;
  logic                startsCycle;
  logic [SET_W-1:0]    curSet;
  logic [SET_W-1:0]    newSet;

  // field order inside one half: setup, hold, width, delay
  function automatic logic [SET_W-1:0] pickSet(input logic wr,
                                               input logic [8*FIELD_W-1:0] t);
    return wr ? t[8*FIELD_W-1:SET_W] : t[SET_W-1:0];
  endfunction

  assign reqReady    = (phase == PH_IDLE);
  assign busy        = (phase != PH_IDLE);
  assign accept      = reqValid && reqReady;
  assign startsCycle = accept && ((reqAddr == A_DATA) ||
                       (reqWrite && ((reqAddr == A_ADDR) || (reqAddr == A_CMD))));

  always_comb begin
    if (reqAddr == A_CMD)       newKind = CY_CMD;
    else if (reqAddr == A_ADDR) newKind = CY_ADDR;
    else if (reqWrite)          newKind = CY_WDATA;
    else                        newKind = CY_RDATA;
  end

  assign newSet = pickSet(newKind != CY_RDATA, timing);
  assign curSet = pickSet(kind != CY_RDATA, timing);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      kind  <= CY_CMD;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (startsCycle) begin
            phase <= PH_SETUP;
            kind  <= newKind;
            cnt   <= newSet[FIELD_W-1:0];
          end
        end
        PH_SETUP: begin
          if (cnt == '0) begin
            phase <= PH_PULSE;
            cnt   <= curSet[3*FIELD_W-1:2*FIELD_W];
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_PULSE: begin
          if (cnt == '0) begin
            phase <= PH_HOLD;
            cnt   <= curSet[2*FIELD_W-1:FIELD_W];
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_HOLD: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (curSet[SET_W-1:3*FIELD_W] == '0) begin
            phase <= PH_IDLE;
          end else begin
            phase <= PH_WAIT;
            cnt   <= curSet[SET_W-1:3*FIELD_W] - 1'b1;
          end
        end
        PH_WAIT: begin
          if (cnt == '0) phase <= PH_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.accept  = accept;
    strobe.launch  = startsCycle;
    strobe.capture = (phase == PH_PULSE) && (cnt == '0) && (kind == CY_RDATA);
    strobe.pulse   = (phase == PH_PULSE);
    strobe.frame   = (phase == PH_SETUP) || (phase == PH_PULSE) || (phase == PH_HOLD);
    strobe.kind    = kind;
  end

endmodule

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int IO_W    = 8,
  parameter int FIELD_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seq_strobe_t          strobe,
  input  logic                 reqWrite,
  input  logic [2:0]           reqAddr,
  input  logic [8*FIELD_W-1:0] reqWdata,
  input  logic [IO_W-1:0]      nandDataIn,
  input  logic                 nandRdy,
  output logic [8*FIELD_W-1:0] timing,
  output logic                 rspValid,
  output logic [8*FIELD_W-1:0] rspData,
  output logic                 nandCeN,
  output logic                 nandCle,
  output logic                 nandAle,
  output logic                 nandWeN,
  output logic                 nandReN,
  output logic [IO_W-1:0]      nandDataOut,
  output logic                 nandDataOe
);

  localparam int REG_W = 8 * FIELD_W;

  logic             ceOn;
  logic [REG_W-1:0] timingQ;
  logic [IO_W-1:0]  outByte;
  logic [REG_W-1:0] readVal;
  logic             isWriteKind;

  always_comb begin
    readVal = '0;
    case (reqAddr)
      A_CFG:   readVal[CE_BIT] = ceOn;
      A_STAT:  readVal[0]      = nandRdy;
      A_TIME:  readVal         = timingQ;
      default: readVal         = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ceOn     <= 1'b0;
      timingQ  <= '0;
      outByte  <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= 1'b0;
      if (strobe.accept && reqWrite) begin
        case (reqAddr)
          A_CFG:   ceOn    <= reqWdata[CE_BIT];
          A_TIME:  timingQ <= reqWdata;
          A_CTRL:  if (reqWdata[RST_BIT]) ceOn <= 1'b0;
          default: ;
        endcase
      end
      if (strobe.launch && reqWrite) outByte <= reqWdata[IO_W-1:0];
      if (strobe.accept && !reqWrite && (reqAddr != A_DATA)) begin
        rspValid <= 1'b1;
        rspData  <= readVal;
      end
      if (strobe.capture) begin
        rspValid <= 1'b1;
        rspData  <= {{(REG_W-IO_W){1'b0}}, nandDataIn};
      end
    end
  end

  assign isWriteKind = (strobe.kind != CY_RDATA);
  assign timing      = timingQ;
  assign nandCeN     = !ceOn;
  assign nandCle     = strobe.frame && (strobe.kind == CY_CMD);
  assign nandAle     = strobe.frame && (strobe.kind == CY_ADDR);
  assign nandWeN     = !(strobe.pulse && isWriteKind);
  assign nandReN     = !(strobe.pulse && !isWriteKind);
  assign nandDataOe  = strobe.frame && isWriteKind;
  assign nandDataOut = outByte;

endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nand_seq_pkg::*;
#(
  parameter int IO_W    = 8,
  parameter int FIELD_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  output logic                 reqReady,
  input  logic                 reqWrite,
  input  logic [2:0]           reqAddr,
  input  logic [8*FIELD_W-1:0] reqWdata,
  output logic                 rspValid,
  output logic [8*FIELD_W-1:0] rspData,
  output logic                 busy,
  output logic                 nandCeN,
  output logic                 nandCle,
  output logic                 nandAle,
  output logic                 nandWeN,
  output logic                 nandReN,
  output logic [IO_W-1:0]      nandDataOut,
  output logic                 nandDataOe,
  input  logic [IO_W-1:0]      nandDataIn,
  input  logic                 nandRdy
);

  seq_strobe_t          strobe;
  logic [8*FIELD_W-1:0] timing;

  nand_seq_ctrl #(.FIELD_W(FIELD_W)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .timing   (timing),
    .reqReady (reqReady),
    .busy     (busy),
    .strobe   (strobe)
  );

  nand_seq_dp #(.IO_W(IO_W), .FIELD_W(FIELD_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqWrite    (reqWrite),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .nandDataIn  (nandDataIn),
    .nandRdy     (nandRdy),
    .timing      (timing),
    .rspValid    (rspValid),
    .rspData     (rspData),
    .nandCeN     (nandCeN),
    .nandCle     (nandCle),
    .nandAle     (nandAle),
    .nandWeN     (nandWeN),
    .nandReN     (nandReN),
    .nandDataOut (nandDataOut),
    .nandDataOe  (nandDataOe)
  );

endmodule

// File: rtl/nand_seq_checker.sv
module nand_seq_checker (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic busy,
  input logic rspValid,
  input logic nandCle,
  input logic nandAle,
  input logic nandWeN,
  input logic nandReN,
  input logic nandDataOe
);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));                                  // R5
  AST_LATCH_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));                                    // R4
  AST_PINS_IN_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN || !nandReN || nandCle || nandAle) |-> busy);    // R7
  AST_WE_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !nandWeN |-> nandDataOe);                                  // R5
  AST_RE_FLOATS_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !nandReN |-> !nandDataOe);                                 // R5
  AST_RSP_AT_RE_END: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandReN) |-> rspValid);                              // R6
  AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));                          // R7

endmodule

bind nand_strobe_seq nand_seq_checker i_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .busy       (busy),
  .rspValid   (rspValid),
  .nandCle    (nandCle),
  .nandAle    (nandAle),
  .nandWeN    (nandWeN),
  .nandReN    (nandReN),
  .nandDataOe (nandDataOe)
);

// File: tb/test_nand_strobe_seq.sv
module test_nand_strobe_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [2:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [7:0]  nandDataIn = 8'h11;
  logic        nandRdy = 1'b1;
  logic        reqReady, rspValid, busy;
  logic [31:0] rspData;
  logic        nandCeN, nandCle, nandAle, nandWeN, nandReN, nandDataOe;
  logic [7:0]  nandDataOut;

  always #4 clk = ~clk;

  nand_strobe_seq i_nand_strobe_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .busy(busy),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandDataOut(nandDataOut),
    .nandDataOe(nandDataOe), .nandDataIn(nandDataIn), .nandRdy(nandRdy)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  // phase codes: 0 idle, 1 setup, 2 pulse, 5 last pulse clock, 3 hold, 4 delay
  int          phaseQ[$];
  int          cur = 0;
  int          mKind = 0;        // 0 cmd, 1 addr, 2 data write, 3 data read
  logic [7:0]  mByte = '0;
  logic        mCe = 1'b0;
  logic [31:0] mTime = '0;
  logic        mRspV = 1'b0;
  logic [31:0] mRspD = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      phaseQ.delete();
      cur = 0; mKind = 0; mByte = '0; mCe = 1'b0; mTime = '0;
      mRspV = 1'b0; mRspD = '0;
    end else begin
      mRspV = 1'b0;
      if (cur == 5 && mKind == 3) begin
        mRspV = 1'b1;
        mRspD = {24'd0, nandDataIn};
      end
      if (reqValid && cur == 0) begin
        if (!reqWrite && reqAddr != 3'd0) begin
          mRspV = 1'b1;
          case (reqAddr)
            3'd4:    mRspD = {26'd0, mCe, 5'd0};
            3'd5:    mRspD = {31'd0, nandRdy};
            3'd6:    mRspD = mTime;
            default: mRspD = 32'd0;
          endcase
        end
        if (reqWrite) begin
          if (reqAddr == 3'd4) mCe = reqWdata[5];
          if (reqAddr == 3'd6) mTime = reqWdata;
          if (reqAddr == 3'd3 && reqWdata[2]) mCe = 1'b0;
        end
        if (reqAddr == 3'd0 || (reqWrite && (reqAddr == 3'd1 || reqAddr == 3'd2))) begin
          int off, s, h, w, d;
          mKind = (reqAddr == 3'd2) ? 0 : (reqAddr == 3'd1) ? 1 : reqWrite ? 2 : 3;
          if (reqWrite) mByte = reqWdata[7:0];
          off = (mKind == 3) ? 0 : 16;
          s = int'((mTime >> off) & 32'hF);
          h = int'((mTime >> (off + 4)) & 32'hF);
          w = int'((mTime >> (off + 8)) & 32'hF);
          d = int'((mTime >> (off + 12)) & 32'hF);
          for (int i = 0; i <= s; i++) phaseQ.push_back(1);
          for (int i = 0; i < w; i++) phaseQ.push_back(2);
          phaseQ.push_back(5);
          for (int i = 0; i <= h; i++) phaseQ.push_back(3);
          for (int i = 0; i < d; i++) phaseQ.push_back(4);
        end
      end
      cur = (phaseQ.size() > 0) ? phaseQ.pop_front() : 0;
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      logic frame, pulse;
      frame = (cur == 1 || cur == 2 || cur == 5 || cur == 3);
      pulse = (cur == 2 || cur == 5);
      check("R7", "reqReady", reqReady, cur == 0);
      check("R7", "busy", busy, cur != 0);
      check("R4", "nandCle", nandCle, frame && mKind == 0);
      check("R4", "nandAle", nandAle, frame && mKind == 1);
      check("R3", "nandWeN", nandWeN, !(pulse && mKind != 3));
      check("R3", "nandReN", nandReN, !(pulse && mKind == 3));
      check("R5", "nandDataOe", nandDataOe, frame && mKind != 3);
      if (frame && mKind != 3) check("R5", "nandDataOut", nandDataOut, mByte);
      check("R8", "nandCeN", nandCeN, !mCe);
      check("R6/R11", "rspValid", rspValid, mRspV);
      if (mRspV) check("R6/R11", "rspData", rspData, mRspD);
    end
  end

  // bus data changes every clock so the sampling clock matters
  always @(negedge clk) nandDataIn = nandDataIn + 8'h35;

  // strobe pulse length monitors
  int weRun = 0, reRun = 0, lastWe = 0, lastRe = 0;
  always @(negedge clk) begin
    if (!nandWeN) weRun++; else if (weRun != 0) begin lastWe = weRun; weRun = 0; end
    if (!nandReN) reRun++; else if (reRun != 0) begin lastRe = reRun; reRun = 0; end
  end

  task automatic access(input logic wr, input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, input logic [31:0] exp, input string req);
    access(1'b0, a, 32'd0);
    @(negedge clk);
    check(req, "register read valid", rspValid, 1'b1);
    check(req, "register read data", rspData, exp);
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R7 watchdog: actual hung expected idle");
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "reset nandWeN", nandWeN, 1'b1);
    check("R1", "reset nandReN", nandReN, 1'b1);
    check("R1", "reset latch lines", {nandCle, nandAle, nandDataOe}, 3'b000);
    check("R1", "reset nandCeN", nandCeN, 1'b1);
    check("R1", "reset reqReady", reqReady, 1'b1);
    readReg(3'd6, 32'd0, "R1");

    // R4 R5 R7: back-to-back command, address, data with zero timing (stalls)
    access(1'b1, 3'd2, 32'h0000_0090);
    access(1'b1, 3'd1, 32'h0000_0000);
    access(1'b1, 3'd0, 32'hFFFF_FFA5);
    access(1'b0, 3'd0, 32'd0);
    access(1'b0, 3'd0, 32'd0);
    waitIdle();
    check("R3", "zero timing write pulse", lastWe, 1);
    check("R3", "zero timing read pulse", lastRe, 1);

    // R8 chip enable
    access(1'b1, 3'd4, 32'h0000_0020);
    @(negedge clk);
    check("R8", "chip enable active", nandCeN, 1'b0);
    readReg(3'd4, 32'h0000_0020, "R8");

    // R2 field layout with a mixed word
    access(1'b1, 3'd6, 32'h2314_0621);
    readReg(3'd6, 32'h2314_0621, "R2");
    access(1'b1, 3'd0, 32'h0000_003C);
    waitIdle();
    check("R2", "write width field gives pulse", lastWe, 4);
    access(1'b0, 3'd0, 32'd0);
    waitIdle();
    check("R2", "read width field gives pulse", lastRe, 7);
    access(1'b1, 3'd2, 32'h0000_0070);
    access(1'b1, 3'd1, 32'h0000_0012);
    waitIdle();

    // R3 largest counts
    access(1'b1, 3'd6, 32'hFFFF_FFFF);
    access(1'b1, 3'd0, 32'h0000_00C3);
    access(1'b0, 3'd0, 32'd0);
    waitIdle();
    check("R3", "max write pulse", lastWe, 16);
    check("R3", "max read pulse", lastRe, 16);

    // R9 ready pin
    nandRdy = 1'b0;
    readReg(3'd5, 32'd0, "R9");
    nandRdy = 1'b1;
    readReg(3'd5, 32'd1, "R9");

    // R11 zero-reading offsets
    readReg(3'd2, 32'd0, "R11");
    readReg(3'd7, 32'd0, "R11");

    // R10 soft reset clears configuration, keeps timing
    access(1'b1, 3'd3, 32'h0000_0004);
    @(negedge clk);
    check("R10", "chip enable released", nandCeN, 1'b1);
    readReg(3'd4, 32'd0, "R10");
    readReg(3'd6, 32'hFFFF_FFFF, "R10");

    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule